// File: doc/BRIEF.md
# Coherent Snapshot Statistics Counter Bank

This block keeps a bank of event counters for a datapath. Every counter adds its increment input into a private running total. No reader ever sees that total directly. When a tick arrives, every running total is copied into a readable snapshot register on the same clock edge, and the running totals restart from zero. Every snapshot therefore covers the same interval. A dedicated cycle counter is captured on the same edge, so software can turn any counter value into a rate.

A tick comes from one of two sources: the `tick_i` pin, or a register write to the tick address. The increment inputs carry more than one unit per cycle, so byte counts can be used. A total that would pass the largest value of the counter width stops at all ones. Software reads the snapshots as 32-bit words. The low word of an entry is at the entry's base address and the high word is at base + 4. The high word is zero-filled above the counter width.

Top module: `stat_snapshot_bank`

## Requirements
- R1: After reset, every snapshot word reads as zero and `rd_valid` is low.
- R2: An increment changes only the running total. It does not change the readable snapshot until the next tick.
- R3: On a tick from `tick_i`, each snapshot takes the running total as it stood before that cycle, and the running total is cleared.
- R4: A write strobe to address 0x000 acts as a tick. A write to any other address changes no snapshot.
- R5: An increment presented in the same cycle as a tick belongs to the new interval. The cleared total starts at that increment's value.
- R6: A running total that would exceed 2^CTR_W-1 holds at 2^CTR_W-1 and never wraps. This also applies to multi-unit increments.
- R7: The cycle-count snapshot equals the number of clock cycles between the two most recent ticks.
- R8: The read map is as follows. The cycle count is at 0x008. Counter k is at 0x010 + 8k. Bits 31:0 are at the base address and bits 63:32 are at base + 4, zero-filled above CTR_W. Read data and `rd_valid` appear one cycle after `rd_en`.
- R9: The following reads return zero: reads of address 0x000, of addresses that are not word-aligned, and of addresses beyond the last counter.
- R10: Snapshot values do not change in any cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | NUM_CTRS*INC_W | Per-counter increment amounts; counter k in bits k*INC_W upward |
| tick_i | input | 1 | Hardware snapshot request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data word |

## Verification
Snapshots change at the clock edge that samples a tick. A read issued at the next falling edge returns data at the falling edge after that, one cycle later. The bench drives every stimulus on a falling edge and holds it for whole cycles. It reads results only after the tick's edge has passed, and samples read data exactly one cycle after the strobe. Cycle-count checks keep the two ticks a known number of edges apart and issue no traffic between them. Saturation is reached by using a 40-bit counter with 32-bit increments, which takes a few hundred cycles.

// File: rtl/stat_snapshot_pkg.sv
package stat_snapshot_pkg;
    localparam int TICK_OFFSET  = 0;
    localparam int CYCLE_SLOT   = 1;
    localparam int FIRST_CTR_SLOT = 2;
    localparam int SLOT_BYTES   = 8;
    localparam int WORD_BITS    = 32;
endpackage

// File: rtl/stat_accum_cell.sv
module stat_accum_cell #(
    parameter int CTR_W = 48,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [INC_W-1:0] inc,
    output logic [CTR_W-1:0] acc_o,
    output logic [CTR_W-1:0] shadow_o
);
    typedef struct packed {
        logic [CTR_W-1:0] acc;
        logic [CTR_W-1:0] shadow;
    } cell_t;

    cell_t st_d, st_q;
    logic [CTR_W-1:0] base;
    logic [CTR_W:0]   sum;

    always_comb begin
        st_d = st_q;
        base = tick ? '0 : st_q.acc;
        sum  = {1'b0, base} + (CTR_W+1)'(inc);
        st_d.acc = sum[CTR_W] ? '1 : sum[CTR_W-1:0];
        if (tick) begin
            st_d.shadow = st_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o    = st_q.acc;
    assign shadow_o = st_q.shadow;
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port #(
    parameter int CTR_W     = 48,
    parameter int NUM_SLOTS = 5,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NUM_SLOTS*CTR_W-1:0] shadow_flat,
    output logic                       rd_valid,
    output logic [31:0]                rd_data
);
    localparam int SLOT_W = ADDR_W - 3;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [SLOT_W-1:0] slot;
    logic              mapped;
    logic [63:0]       ext;

    always_comb begin
        rd_d   = rd_q;
        slot   = rd_addr[ADDR_W-1:3];
        mapped = (rd_addr[1:0] == 2'b00) && (slot != '0)
                 && (slot <= SLOT_W'(NUM_SLOTS));
        ext = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (mapped && slot == SLOT_W'(s + 1)) begin
                ext = 64'(shadow_flat[s*CTR_W +: CTR_W]);
            end
        end
        rd_d.valid = rd_en;
        if (rd_en) begin
            rd_d.data = rd_addr[2] ? ext[63:32] : ext[31:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;
endmodule

// File: rtl/stat_snapshot_bank.sv
module stat_snapshot_bank
    import stat_snapshot_pkg::*;
#(
    parameter int NUM_CTRS = 4,
    parameter int CTR_W    = 48,
    parameter int INC_W    = 16,
    parameter int ADDR_W   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CTRS*INC_W-1:0] inc_i,
    input  logic                      tick_i,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      rd_valid,
    output logic [31:0]               rd_data
);
    localparam int NUM_SLOTS = NUM_CTRS + 1;

    logic                       tick_now;
    logic [NUM_SLOTS*CTR_W-1:0] acc_flat;
    logic [NUM_SLOTS*CTR_W-1:0] shadow_flat;

    always_comb begin
        tick_now = tick_i || (wr_en && wr_addr == ADDR_W'(TICK_OFFSET));
    end

    stat_accum_cell #(.CTR_W(CTR_W), .INC_W(1)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_now),
        .inc      (1'b1),
        .acc_o    (acc_flat[0 +: CTR_W]),
        .shadow_o (shadow_flat[0 +: CTR_W])
    );

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_ctr
        stat_accum_cell #(.CTR_W(CTR_W), .INC_W(INC_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_now),
            .inc      (inc_i[k*INC_W +: INC_W]),
            .acc_o    (acc_flat[(k+1)*CTR_W +: CTR_W]),
            .shadow_o (shadow_flat[(k+1)*CTR_W +: CTR_W])
        );
    end

    stat_read_port #(.CTR_W(CTR_W), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .shadow_flat (shadow_flat),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/stat_snapshot_bank_chk.sv
module stat_snapshot_bank_chk #(
    parameter int NUM_CTRS = 4,
    parameter int CTR_W    = 48,
    parameter int INC_W    = 16,
    parameter int ADDR_W   = 12
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CTRS*INC_W-1:0]       inc_i,
    input logic                            tick_i,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic                            rd_en,
    input logic                            rd_valid,
    input logic [(NUM_CTRS+1)*CTR_W-1:0]   acc_flat,
    input logic [(NUM_CTRS+1)*CTR_W-1:0]   shadow_flat
);
    logic port_tick;
    assign port_tick = tick_i || (wr_en && wr_addr == '0);

    // Snapshots move only on a tick seen at the ports (R4, R10)
    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_tick |=> $stable(shadow_flat));

    assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_chk
        assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
            port_tick |=> acc_flat[(k+1)*CTR_W +: CTR_W]
                          == CTR_W'($past(inc_i[k*INC_W +: INC_W])));

        assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !port_tick |=> acc_flat[(k+1)*CTR_W +: CTR_W]
                           >= $past(acc_flat[(k+1)*CTR_W +: CTR_W]));

        assert_snap_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
            port_tick |=> shadow_flat[(k+1)*CTR_W +: CTR_W]
                          == $past(acc_flat[(k+1)*CTR_W +: CTR_W]));
    end
endmodule

bind stat_snapshot_bank stat_snapshot_bank_chk #(
    .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .INC_W(INC_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc_i),
    .tick_i      (tick_i),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .acc_flat    (acc_flat),
    .shadow_flat (shadow_flat)
);

// File: tb/stat_snapshot_bank_tb.sv
`timescale 1ns/1ps
module stat_snapshot_bank_tb;
    localparam int NUM_CTRS = 3;
    localparam int CTR_W    = 40;
    localparam int INC_W    = 32;
    localparam int ADDR_W   = 12;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_CTRS*INC_W-1:0] inc_i = '0;
    logic                      tick_i = 1'b0;
    logic                      wr_en = 1'b0;
    logic [ADDR_W-1:0]         wr_addr = '0;
    logic                      rd_en = 1'b0;
    logic [ADDR_W-1:0]         rd_addr = '0;
    logic                      rd_valid;
    logic [31:0]               rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    stat_snapshot_bank #(.NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .INC_W(INC_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .tick_i(tick_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [ADDR_W-1:0] ctr_addr(input int k, input bit hi);
        return ADDR_W'(16 + 8*k + (hi ? 4 : 0));
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic expect_word(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d; logic v;
        do_read(a, d, v);
        check(v == 1'b1, {req, " valid"}, 64'(v), 64'd1);
        check(d == exp, req, 64'(d), 64'(exp));
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic drive_inc(input int k, input logic [INC_W-1:0] val, input int n);
        @(negedge clk);
        inc_i[k*INC_W +: INC_W] = val;
        for (int i = 1; i < n; i++) @(negedge clk);
        @(negedge clk);
        inc_i[k*INC_W +: INC_W] = '0;
    endtask
    // drive_inc leaves the value on for exactly n rising edges

    task automatic t_reset();
        logic [31:0] d; logic v;
        check(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
        expect_word(12'h008, 32'h0, "R1 cycle lsb");
        expect_word(ctr_addr(0, 0), 32'h0, "R1 ctr0 lsb");
        expect_word(ctr_addr(2, 1), 32'h0, "R1 ctr2 msb");
        do_read(12'h010, d, v);
    endtask

    task automatic t_accumulate();
        pulse_tick();
        drive_inc(0, 32'd5, 4);
        expect_word(ctr_addr(0, 0), 32'd0, "R2 hidden before tick");
        pulse_tick();
        expect_word(ctr_addr(0, 0), 32'd20, "R3 snapshot sum");
        pulse_tick();
        expect_word(ctr_addr(0, 0), 32'd0, "R3 cleared after tick");
    endtask

    task automatic t_sw_tick();
        drive_inc(1, 32'd7, 2);
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h004;
        @(negedge clk); wr_en = 1'b0;
        expect_word(ctr_addr(1, 0), 32'd0, "R4 other write no tick");
        @(negedge clk); wr_en = 1'b1; wr_addr = 12'h000;
        @(negedge clk); wr_en = 1'b0;
        expect_word(ctr_addr(1, 0), 32'd14, "R4 tick by write");
    endtask

    task automatic t_tick_cycle_inc();
        drive_inc(0, 32'd3, 1);
        @(negedge clk); tick_i = 1'b1; inc_i[0 +: INC_W] = 32'd9;
        @(negedge clk); tick_i = 1'b0; inc_i[0 +: INC_W] = '0;
        expect_word(ctr_addr(0, 0), 32'd3, "R5 old interval");
        pulse_tick();
        expect_word(ctr_addr(0, 0), 32'd9, "R5 new interval");
    endtask

    task automatic t_cycle(input int n);
        pulse_tick();
        for (int i = 1; i < n; i++) @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        expect_word(12'h008, 32'(n), "R7 cycle count");
        expect_word(12'h00C, 32'h0, "R8 cycle msb");
    endtask

    task automatic t_wide();
        pulse_tick();
        drive_inc(2, 32'hFFFF_FFFF, 3);
        pulse_tick();
        expect_word(ctr_addr(2, 0), 32'hFFFF_FFFD, "R8 lsb word");
        expect_word(ctr_addr(2, 1), 32'h0000_0002, "R8 msb word");
    endtask

    task automatic t_saturate();
        pulse_tick();
        drive_inc(2, 32'hFFFF_FFFF, 300);
        pulse_tick();
        expect_word(ctr_addr(2, 0), 32'hFFFF_FFFF, "R6 saturated lsb");
        expect_word(ctr_addr(2, 1), 32'h0000_00FF, "R6 R8 saturated msb zero fill");
    endtask

    task automatic t_unmapped();
        expect_word(12'h000, 32'h0, "R9 tick address");
        expect_word(12'h012, 32'h0, "R9 misaligned");
        expect_word(12'h028, 32'h0, "R9 beyond last");
    endtask

    task automatic t_hold();
        drive_inc(2, 32'd11, 5);
        expect_word(ctr_addr(2, 1), 32'h0000_00FF, "R10 held msb");
        drive_inc(2, 32'd1, 2);
        expect_word(ctr_addr(2, 0), 32'hFFFF_FFFF, "R10 held lsb");
        pulse_tick();
        expect_word(ctr_addr(2, 0), 32'd57, "R10 next snapshot");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_accumulate();
        t_sw_tick();
        t_tick_cycle_inc();
        t_cycle(37);
        t_cycle(5);
        t_wide();
        t_saturate();
        t_unmapped();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule